// File: doc/BRIEF.md
# Remote Input Read Transaction Engine

This block sits on the master side of a real-time I/O link and carries out reads of input channels that live on remote nodes. A local requester places a channel number and a timeout on its inputs and pulses a read command for one cycle. The engine turns that command into a single read-request packet for the remote node. It then waits for the remote node's reply and presents the outcome as a status word, together with the captured timestamp and data.

The status word has one bit each for "read in progress", "no event before timeout", "input overflow" and "destination unreachable". A reply from the remote side either carries an event (a timestamp and a data word) or reports that no event arrived, with a flag that tells a plain timeout from an overflow. Reachability of each remote destination comes from a per-destination link-up vector. The destination of a channel is given by the top bits of the channel number. A read aimed at a destination that is down finishes at once and sends nothing.

Only one read is in flight at a time. Read commands that arrive while a read is pending are dropped. Replies that arrive when none is expected are dropped and flagged with a one-cycle error strobe.

Top module: `rin_read_engine`

## Requirements
- R1: A read command (`rd_cmd` = 2) issued while no read is pending sets status bit 2 (value 0x4, pending) from the cycle after the command. The nop code 0 and the code 1 start nothing.
- R2: The pending bit stays set until a reply is accepted after the request packet has been handed off, and it clears in the cycle after that reply.
- R3: Each read raises `req_valid` exactly once. The request carries the channel and timeout sampled in the command cycle, and these fields are held stable until `req_ready` is seen high.
- R4: An event reply (`rsp_event` = 1) latches `rsp_timestamp` and `rsp_data` into `rd_timestamp` and `rd_data`, and the status word reads 0 in the following cycle.
- R5: A no-event reply (`rsp_event` = 0) sets status bit 0 (0x1, timeout) when `rsp_overflow` = 0, and status bit 1 (0x2, overflow) when `rsp_overflow` = 1. The timestamp and data outputs keep their previous values.
- R6: A read command that arrives while a read is pending is ignored. The outstanding request's fields stay as they were, and no extra request is emitted.
- R7: The destination index is the upper `DEST_W` bits of the channel. If the matching bit of `dest_up` is 0 when a read command arrives, no request is sent and the status reads 0x8 (bit 3) in the next cycle, with the pending bit never set.
- R8: A reply received while no request is awaiting its answer is discarded. Status, timestamp and data stay unchanged, and `proto_err` is high in the following cycle only.
- R9: After reset, status reads 0, `rd_timestamp` and `rd_data` read 0, and `req_valid` and `proto_err` are low.
- R10: Starting a new read clears every error bit left by the previous read, so the status reads exactly 0x4 while the read is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_chan | input | CHAN_W | Channel to read |
| rd_timeout | input | TO_W | Timeout value forwarded to the remote node |
| rd_cmd | input | 2 | Command: 0 nop, 1 write (ignored here), 2 read |
| dest_up | input | 2**DEST_W | Per-destination reachability, 1 = reachable |
| rd_status | output | 4 | bit0 timeout, bit1 overflow, bit2 pending, bit3 unreachable |
| rd_timestamp | output | TS_W | Timestamp of the last event read |
| rd_data | output | DATA_W | Data of the last event read |
| req_valid | output | 1 | Read-request packet valid |
| req_ready | input | 1 | Packet sink accepts the request |
| req_chan | output | CHAN_W | Request channel field |
| req_timeout | output | TO_W | Request timeout field |
| rsp_valid | input | 1 | Reply packet strobe |
| rsp_event | input | 1 | 1 = event reply, 0 = no-event reply |
| rsp_overflow | input | 1 | Overflow flag of a no-event reply |
| rsp_timestamp | input | TS_W | Event timestamp |
| rsp_data | input | DATA_W | Event data |
| proto_err | output | 1 | One-cycle strobe for an unexpected reply |

## Verification
Every result of this block is registered once. The pending bit and `req_valid` appear one cycle after the command edge. Request fields are valid for as long as `req_valid` is high, and `req_valid` drops one cycle after the `req_ready` edge. Status, timestamp, data and `proto_err` respond one cycle after the reply edge, and the unreachable code one cycle after the command edge. The bench drives every input on the falling edge and reads the outputs on the next falling edge, so each check lands half a cycle after the rising edge that should have produced it.

// File: rtl/rin_pkg.sv
package rin_pkg;
  localparam logic [1:0] CMD_NOP   = 2'd0;
  localparam logic [1:0] CMD_WRITE = 2'd1;
  localparam logic [1:0] CMD_READ  = 2'd2;

  localparam int STAT_TIMEOUT = 0;
  localparam int STAT_OVERFLOW = 1;
  localparam int STAT_PENDING = 2;
  localparam int STAT_UNREACH = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } rd_state_e;
endpackage

// File: rtl/rin_dest_lookup.sv
module rin_dest_lookup #(
  parameter int CHAN_W = 8,
  parameter int DEST_W = 2,
  localparam int NUM_DEST = 1 << DEST_W
) (
  input  logic [CHAN_W-1:0]   chan,
  input  logic [NUM_DEST-1:0] dest_up,
  output logic                reachable
);
  generate
    if (DEST_W == 0) begin : g_single
      assign reachable = dest_up[0];
    end else begin : g_indexed
      logic [DEST_W-1:0] dest_idx;
      assign dest_idx  = chan[CHAN_W-1 -: DEST_W];
      assign reachable = dest_up[dest_idx];
    end
  endgenerate
endmodule

// File: rtl/rin_read_fsm.sv
module rin_read_fsm
  import rin_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cmd,
  input  logic       reachable,
  input  logic       req_fire,
  input  logic       rsp_valid,
  output logic       launch,
  output logic       unreach_done,
  output logic       rsp_take,
  output logic       pending,
  output logic       proto_err
);
  rd_state_e state_q, state_d;
  logic      is_read;

  assign is_read = (cmd == CMD_READ);

  always_comb begin
    state_d      = state_q;
    launch       = 1'b0;
    unreach_done = 1'b0;
    rsp_take     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (is_read) begin
          if (reachable) begin
            launch  = 1'b1;
            state_d = ST_SEND;
          end else begin
            unreach_done = 1'b1;
          end
        end
      end
      ST_SEND: begin
        if (req_fire) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rsp_valid) begin
          rsp_take = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      proto_err <= 1'b0;
    end else begin
      state_q   <= state_d;
      proto_err <= rsp_valid && (state_q != ST_WAIT);
    end
  end

  assign pending = (state_q != ST_IDLE);

  AST_TAKE_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    rsp_take |=> !pending || launch); // R2
endmodule

// File: rtl/rin_req_port.sv
module rin_req_port #(
  parameter int CHAN_W = 8,
  parameter int TO_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [CHAN_W-1:0] chan_in,
  input  logic [TO_W-1:0]   to_in,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [CHAN_W-1:0] req_chan,
  output logic [TO_W-1:0]   req_timeout,
  output logic              req_fire
);
  assign req_fire = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid   <= 1'b0;
      req_chan    <= '0;
      req_timeout <= '0;
    end else begin
      if (launch) begin
        req_valid   <= 1'b1;
        req_chan    <= chan_in;
        req_timeout <= to_in;
      end else if (req_fire) begin
        req_valid <= 1'b0;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_chan) && $stable(req_timeout)); // R3
  AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (rst)
    launch |-> !req_valid); // R6
endmodule

// File: rtl/rin_result.sv
module rin_result #(
  parameter int TS_W   = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              unreach_done,
  input  logic              rsp_take,
  input  logic              rsp_event,
  input  logic              rsp_overflow,
  input  logic [TS_W-1:0]   rsp_ts,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              err_timeout,
  output logic              err_overflow,
  output logic              err_unreach,
  output logic [TS_W-1:0]   rd_ts,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      err_timeout  <= 1'b0;
      err_overflow <= 1'b0;
      err_unreach  <= 1'b0;
      rd_ts        <= '0;
      rd_data      <= '0;
    end else if (launch) begin
      err_timeout  <= 1'b0;
      err_overflow <= 1'b0;
      err_unreach  <= 1'b0;
    end else if (unreach_done) begin
      err_timeout  <= 1'b0;
      err_overflow <= 1'b0;
      err_unreach  <= 1'b1;
    end else if (rsp_take) begin
      err_unreach <= 1'b0;
      if (rsp_event) begin
        err_timeout  <= 1'b0;
        err_overflow <= 1'b0;
        rd_ts        <= rsp_ts;
        rd_data      <= rsp_data;
      end else begin
        err_timeout  <= !rsp_overflow;
        err_overflow <= rsp_overflow;
      end
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $countones({launch, unreach_done, rsp_take}) <= 1); // R7
endmodule

// File: rtl/rin_read_engine.sv
module rin_read_engine #(
  parameter int CHAN_W = 8,
  parameter int DEST_W = 2,
  parameter int TO_W   = 32,
  parameter int TS_W   = 32,
  parameter int DATA_W = 32,
  localparam int NUM_DEST = 1 << DEST_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CHAN_W-1:0]   rd_chan,
  input  logic [TO_W-1:0]     rd_timeout,
  input  logic [1:0]          rd_cmd,
  input  logic [NUM_DEST-1:0] dest_up,
  output logic [3:0]          rd_status,
  output logic [TS_W-1:0]     rd_timestamp,
  output logic [DATA_W-1:0]   rd_data,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [CHAN_W-1:0]   req_chan,
  output logic [TO_W-1:0]     req_timeout,
  input  logic                rsp_valid,
  input  logic                rsp_event,
  input  logic                rsp_overflow,
  input  logic [TS_W-1:0]     rsp_timestamp,
  input  logic [DATA_W-1:0]   rsp_data,
  output logic                proto_err
);
  import rin_pkg::*;

  logic reachable, launch, unreach_done, rsp_take, pending, req_fire;
  logic err_timeout, err_overflow, err_unreach;

  rin_dest_lookup #(.CHAN_W(CHAN_W), .DEST_W(DEST_W)) u_lookup (
    .chan(rd_chan), .dest_up(dest_up), .reachable(reachable));

  rin_read_fsm u_fsm (
    .clk(clk), .rst(rst), .cmd(rd_cmd), .reachable(reachable),
    .req_fire(req_fire), .rsp_valid(rsp_valid), .launch(launch),
    .unreach_done(unreach_done), .rsp_take(rsp_take),
    .pending(pending), .proto_err(proto_err));

  rin_req_port #(.CHAN_W(CHAN_W), .TO_W(TO_W)) u_req (
    .clk(clk), .rst(rst), .launch(launch), .chan_in(rd_chan),
    .to_in(rd_timeout), .req_ready(req_ready), .req_valid(req_valid),
    .req_chan(req_chan), .req_timeout(req_timeout), .req_fire(req_fire));

  rin_result #(.TS_W(TS_W), .DATA_W(DATA_W)) u_res (
    .clk(clk), .rst(rst), .launch(launch), .unreach_done(unreach_done),
    .rsp_take(rsp_take), .rsp_event(rsp_event), .rsp_overflow(rsp_overflow),
    .rsp_ts(rsp_timestamp), .rsp_data(rsp_data),
    .err_timeout(err_timeout), .err_overflow(err_overflow),
    .err_unreach(err_unreach), .rd_ts(rd_timestamp), .rd_data(rd_data));

  always_comb begin
    rd_status = '0;
    rd_status[STAT_TIMEOUT]  = err_timeout;
    rd_status[STAT_OVERFLOW] = err_overflow;
    rd_status[STAT_PENDING]  = pending;
    rd_status[STAT_UNREACH]  = err_unreach;
  end

  AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_status)); // R5
  AST_PEND_NOERR: assert property (@(posedge clk) disable iff (rst)
    rd_status[2] |-> rd_status == 4'h4); // R10
  AST_UNREACH_NOPKT: assert property (@(posedge clk) disable iff (rst)
    unreach_done |=> !req_valid && rd_status == 4'h8); // R7
endmodule

// File: tb/sim_rin_read_engine.sv
module sim_rin_read_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  rd_chan = '0;
  logic [31:0] rd_timeout = '0;
  logic [1:0]  rd_cmd = 2'd0;
  logic [3:0]  dest_up = 4'hF;
  logic [3:0]  rd_status;
  logic [31:0] rd_timestamp, rd_data;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [7:0]  req_chan;
  logic [31:0] req_timeout;
  logic        rsp_valid = 1'b0, rsp_event = 1'b0, rsp_overflow = 1'b0;
  logic [31:0] rsp_timestamp = '0, rsp_data = '0;
  logic        proto_err;

  int checks = 0, fails = 0, fires = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rin_read_engine u0 (.*);

  always @(posedge clk) if (!rst && req_valid && req_ready) fires <= fires + 1;

  typedef struct packed {
    logic [7:0]  chan;
    logic [31:0] to;
    logic [1:0]  kind;   // 0 event, 1 no-event, 2 no-event with overflow
    logic [31:0] ts;
    logic [31:0] data;
    logic [3:0]  dly;
    logic [3:0]  exp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'd19,  32'd145, 2'd0, 32'd333,  32'd23,   4'd0, 4'h0},
    '{8'd20,  32'd146, 2'd0, 32'd334,  32'd24,   4'd2, 4'h0},
    '{8'd10,  32'd34,  2'd1, 32'd0,    32'd0,    4'd1, 4'h1},
    '{8'd1,   32'd20,  2'd2, 32'd0,    32'd0,    4'd3, 4'h2},
    '{8'd21,  32'd147, 2'd0, 32'd335,  32'd25,   4'd0, 4'h0},
    '{8'd200, 32'd500, 2'd0, 32'hDEAD, 32'hBEEF, 4'd1, 4'h0}
  };

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] ch, input logic [31:0] to);
    @(negedge clk);
    rd_chan = ch; rd_timeout = to; rd_cmd = 2'd2;
    @(negedge clk);
    rd_cmd = 2'd0;
  endtask

  task automatic handshake(input int dly);
    for (int i = 0; i < dly; i++) @(negedge clk);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
  endtask

  task automatic reply(input logic ev, input logic ov, input logic [31:0] ts, input logic [31:0] d);
    rsp_valid = 1'b1; rsp_event = ev; rsp_overflow = ov; rsp_timestamp = ts; rsp_data = d;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] last_ts, last_d;
    int f0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 status", rd_status, 4'h0);
    chk("R9 timestamp", rd_timestamp, 0);
    chk("R9 data", rd_data, 0);
    chk("R9 req_valid", req_valid, 0);
    chk("R9 proto_err", proto_err, 0);
    last_ts = 0; last_d = 0;

    // table walk
    foreach (VECS[k]) begin
      f0 = fires;
      issue(VECS[k].chan, VECS[k].to);
      chk("R1/R10 pending after start", rd_status, 4'h4);
      chk("R3 req_valid", req_valid, 1);
      chk("R3 req_chan", req_chan, VECS[k].chan);
      chk("R3 req_timeout", req_timeout, VECS[k].to);
      handshake(VECS[k].dly);
      chk("R3 req_valid drops", req_valid, 0);
      chk("R2 still pending", rd_status, 4'h4);
      reply(VECS[k].kind == 2'd0, VECS[k].kind == 2'd2, VECS[k].ts, VECS[k].data);
      if (VECS[k].kind == 2'd0) begin
        last_ts = VECS[k].ts; last_d = VECS[k].data;
      end
      chk("R4/R5 status", rd_status, VECS[k].exp);
      chk("R4/R5 timestamp", rd_timestamp, last_ts);
      chk("R4/R5 data", rd_data, last_d);
      chk("R3 one request", fires - f0, 1);
    end

    // R1: nop and write codes start nothing
    @(negedge clk);
    rd_cmd = 2'd1; rd_chan = 8'd7;
    @(negedge clk);
    rd_cmd = 2'd0;
    chk("R1 write code ignored", rd_status, 4'h0);
    chk("R1 no request", req_valid, 0);

    // R6: read while pending ignored
    f0 = fires;
    issue(8'd5, 32'd77);
    issue(8'd9, 32'd88);
    chk("R6 chan kept", req_chan, 8'd5);
    chk("R6 timeout kept", req_timeout, 32'd77);
    chk("R6 still pending", rd_status, 4'h4);
    handshake(0);
    issue(8'd11, 32'd99);
    chk("R6 no new request while waiting", req_valid, 0);
    reply(1'b1, 1'b0, 32'h1234, 32'h5678);
    chk("R6 completes", rd_status, 4'h0);
    chk("R6 single request", fires - f0, 1);

    // R8: stray reply while idle
    reply(1'b1, 1'b0, 32'h9999, 32'h8888);
    chk("R8 proto_err", proto_err, 1);
    chk("R8 status kept", rd_status, 4'h0);
    chk("R8 timestamp kept", rd_timestamp, 32'h1234);
    chk("R8 data kept", rd_data, 32'h5678);
    @(negedge clk);
    chk("R8 proto_err one cycle", proto_err, 0);

    // R8: reply during send phase is also unexpected
    issue(8'd3, 32'd4);
    reply(1'b0, 1'b1, 32'h0, 32'h0);
    chk("R8 proto_err in send", proto_err, 1);
    chk("R8 pending kept", rd_status, 4'h4);
    handshake(0);
    reply(1'b0, 1'b0, 32'h0, 32'h0);
    chk("R5 timeout code", rd_status, 4'h1);

    // R7: unreachable destination (chan 10 -> dest 0, chan 130 -> dest 2)
    dest_up = 4'b1010;
    f0 = fires;
    issue(8'd10, 32'd34);
    chk("R7 unreachable status", rd_status, 4'h8);
    chk("R7 no request", req_valid, 0);
    issue(8'd130, 32'd1);
    chk("R7 dest2 unreachable", rd_status, 4'h8);
    issue(8'd70, 32'd2);
    chk("R7/R10 dest1 reachable clears", rd_status, 4'h4);
    chk("R7 request for reachable", req_chan, 8'd70);
    handshake(0);
    reply(1'b1, 1'b0, 32'h42, 32'h43);
    chk("R7 completes", rd_status, 4'h0);
    chk("R7 request count", fires - f0, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule